// File: doc/BRIEF.md
# Page Load Buffer with Timed Commit

This block gathers single-byte writes into a 64-entry page register and then copies them into a byte array in one self-timed programming pass. The write port uses two active-low enables. The address is taken when the second of the two enables goes low. The data is taken when the first of them goes high. Both enable inputs are sampled on the system clock. Every byte in one load period belongs to the same page. A byte may arrive in any order and may be written again before the load ends.

Loading ends when no write on the current page arrives within the byte-load window. The programming pass then starts. It copies only the byte positions that were marked as loaded. It keeps the busy flag high for a fixed number of cycles, and no write is accepted while busy is high. An unlock detector outside the block supplies a permission flag. The block samples that flag only on the first write of a load. A write made without permission starts a programming pass that stores nothing. The most recent accepted address and data stay on dedicated outputs, where status logic can poll them. Both durations are parameters counted in clock cycles. At 250 MHz the default window is 100 µs and the default programming pass is 10 ms.

Top module: `pgload_ctrl`

## Requirements
- R1: After reset the outputs are in this state: `busy` is 0, `arr_we` is 0, and `last_addr` and `last_data` are 0.
- R2: The two enables `we_n` and `ce_n` are active low, and a write is active only while both are low. The address is captured on the clock edge where the later of the two enables is first sampled low. The data is captured on the edge where the first of them is sampled high again. The design gives the same result whichever enable makes the pulse.
- R3: Address bits [12:6] select the page and bits [5:0] select the byte within the page. When a permitted load of 1 to 64 bytes, written in any order, finishes programming, the array holds every loaded byte at its page and byte position.
- R4: When one byte position is written more than once within a load, the value written last is the value stored.
- R5: Programming writes only the positions loaded in the current period. Every other array location keeps its earlier value.
- R6: A write in the current page is accepted if it arrives no more than `LOAD_TO` cycles after the previous accepted write. A write landing exactly `LOAD_TO` cycles later is still accepted. If `LOAD_TO` cycles pass with no accepted write, `busy` rises on that edge and loading ends.
- R7: During loading, a write whose page bits differ from the first write's page is ignored. It is not stored, it does not update `last_addr` or `last_data`, and it does not extend the byte-load window.
- R8: `busy` stays high for exactly max(`PROG_CYC`, 68) cycles. Any write made while `busy` is high is ignored.
- R9: If `wr_permit` is 0 at the first write of a load, `busy` rises on the accepting edge and stays high for a full programming pass. During that pass `arr_we` never pulses and the array is left unchanged.
- R10: `last_addr` and `last_data` hold the address and data of the most recent accepted write. This includes a first write made without permission.
- R11: The loaded-position mask clears when programming ends. The next programming pass therefore pulses `arr_we` exactly once for each distinct position loaded in its own period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| we_n | input | 1 | Write enable, active low |
| ce_n | input | 1 | Chip enable, active low |
| addr | input | ADDR_W | Write address |
| wdata | input | DATA_W | Write data |
| wr_permit | input | 1 | Write permission from the unlock detector |
| rd_addr | input | MEM_AW | Array read address |
| rd_data | output | DATA_W | Array read data, one cycle after `rd_addr` |
| busy | output | 1 | High while a programming pass runs |
| last_addr | output | ADDR_W | Address of the last accepted write |
| last_data | output | DATA_W | Data of the last accepted write |
| arr_we | output | 1 | Array write enable for one commit beat |
| arr_waddr | output | ADDR_W | Array write address for the beat |
| arr_wdata | output | DATA_W | Array write data for the beat |

## Verification
The main function is tried with several load patterns:
- A full page written in descending byte order, which separates correct position decoding from order-dependent mistakes.
- Loads that rewrite one position, which show whether the value written last wins.
- Sparse loads into a page that already holds data, which expose commits of stale or unloaded positions.
- A sweep that loads three bytes into every page of the array, with one position repeated, followed by a full comparison of the array against a model computed in the bench.

The window tests cover several cases. Gaps of exactly `LOAD_TO` and `LOAD_TO + 1` cycles separate acceptance from timeout. A write to a foreign page shows that the window is not extended. Writes made while `busy` is high and an unpermitted first write confirm that nothing is stored. Writes pulsed by chip enable and by overlapping enables show which edge captures the address and which captures the data.

// File: rtl/pgload_pkg.sv
package pgload_pkg;

  // Controller phases: waiting for a first write, collecting bytes,
  // walking the page register, waiting out the programming time.
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_COMMIT = 2'd2,
    ST_HOLD   = 2'd3
  } pg_state_t;

endpackage

// File: rtl/pgload_strobe.sv
// Turns the two active-low enables into a one-cycle write strobe.
// The address is taken when the write becomes active (the later falling enable).
// The data is taken when it ends (the first rising enable).
module pgload_strobe #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_n,
  input  logic              ce_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              stb,
  output logic [ADDR_W-1:0] stb_addr,
  output logic [DATA_W-1:0] stb_data
);

  logic              sel;
  logic              sel_q;
  logic [ADDR_W-1:0] addr_cap;

  assign sel = ~we_n & ~ce_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= 1'b0;
      stb      <= 1'b0;
      addr_cap <= '0;
      stb_addr <= '0;
      stb_data <= '0;
    end else begin
      sel_q <= sel;
      stb   <= sel_q & ~sel;
      if (sel & ~sel_q) begin
        addr_cap <= addr;
      end
      if (sel_q & ~sel) begin
        stb_addr <= addr_cap;
        stb_data <= wdata;
      end
    end
  end

endmodule

// File: rtl/pgload_tick.sv
// Saturating cycle counter with a synchronous clear.
module pgload_tick #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (cnt != {CW{1'b1}}) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pgload_pagebuf.sv
// Page register: RAM-style byte storage plus a loaded-position mask.
// The read port is registered so the byte storage can map to block RAM.
module pgload_pagebuf #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_mask,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic [DATA_W-1:0] rd_data
);

  localparam int SLOTS = 1 << IDX_W;

  logic [DATA_W-1:0] slot_mem [SLOTS];
  logic [SLOTS-1:0]  mask;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      slot_mem[wr_idx] <= wr_data;
    end
    rd_data <= slot_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst || clr_mask) begin
      mask <= '0;
    end else if (wr_en) begin
      mask[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld <= 1'b0;
    end else begin
      rd_vld <= mask[rd_idx];
    end
  end

endmodule

// File: rtl/pgload_array.sv
// Behavioural byte array: one synchronous write port, one registered read port.
module pgload_array #(
  parameter int AW     = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdat,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdat
);

  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] cells [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      cells[i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdat;
    end
    rdat <= cells[raddr];
  end

endmodule

// File: rtl/pgload_ctrl.sv
module pgload_ctrl
  import pgload_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int BYTE_W   = 6,
  parameter int MEM_AW   = 11,
  parameter int LOAD_TO  = 25000,
  parameter int PROG_CYC = 2500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_n,
  input  logic              ce_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_permit,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic [ADDR_W-1:0] last_addr,
  output logic [DATA_W-1:0] last_data,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [DATA_W-1:0] arr_wdata
);

  localparam int PAGE_W     = ADDR_W - BYTE_W;
  localparam int PAGE_BYTES = 1 << BYTE_W;
  // The commit walk needs one cycle per slot plus the pipeline stages.
  localparam int PROG_MIN   = PAGE_BYTES + 4;
  localparam int PROG_EFF   = (PROG_CYC > PROG_MIN) ? PROG_CYC : PROG_MIN;
  localparam int LCW        = $clog2(LOAD_TO + 1);
  localparam int PCW        = $clog2(PROG_EFF + 1);

  // Write strobe formed from the two enables
  logic              stb;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_data;

  pgload_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
    .clk      (clk),
    .rst      (rst),
    .we_n     (we_n),
    .ce_n     (ce_n),
    .addr     (addr),
    .wdata    (wdata),
    .stb      (stb),
    .stb_addr (s_addr),
    .stb_data (s_data)
  );

  pg_state_t         st, st_n;
  logic [PAGE_W-1:0] page_q;
  logic [BYTE_W-1:0] cm_idx;
  logic [BYTE_W-1:0] idx_q;
  logic              commit_q;

  logic same_pg, acc_first, acc_load, acc, buf_we;
  logic load_timeout, enter_prog, clr_mask, prog_done;

  logic [LCW-1:0] lcnt;
  logic [PCW-1:0] pcnt;

  assign same_pg   = (s_addr[ADDR_W-1:BYTE_W] == page_q);
  assign acc_first = (st == ST_IDLE) && stb;
  assign acc_load  = (st == ST_LOAD) && stb && same_pg;
  assign acc       = acc_first || acc_load;
  assign buf_we    = (acc_first && wr_permit) || acc_load;

  assign load_timeout = (st == ST_LOAD) && !acc_load && (lcnt == LCW'(LOAD_TO - 1));
  assign prog_done    = (pcnt == PCW'(PROG_EFF - 1));

  // Byte-load window: restarted by every accepted write
  pgload_tick #(.CW(LCW)) u_gap_tick (
    .clk (clk),
    .rst (rst),
    .clr (acc),
    .cnt (lcnt)
  );

  // Programming time: restarted when programming begins
  pgload_tick #(.CW(PCW)) u_prog_tick (
    .clk (clk),
    .rst (rst),
    .clr (enter_prog),
    .cnt (pcnt)
  );

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE: begin
        if (stb) begin
          st_n = wr_permit ? ST_LOAD : ST_COMMIT;
        end
      end
      ST_LOAD: begin
        if (load_timeout) begin
          st_n = ST_COMMIT;
        end
      end
      ST_COMMIT: begin
        if (cm_idx == {BYTE_W{1'b1}}) begin
          st_n = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (prog_done) begin
          st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign enter_prog = (st_n == ST_COMMIT) && (st != ST_COMMIT);
  assign clr_mask   = (st == ST_HOLD) && prog_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      page_q <= '0;
      cm_idx <= '0;
      busy   <= 1'b0;
    end else begin
      st   <= st_n;
      busy <= (st_n == ST_COMMIT) || (st_n == ST_HOLD);
      if (acc_first) begin
        page_q <= s_addr[ADDR_W-1:BYTE_W];
      end
      if (st == ST_COMMIT) begin
        cm_idx <= cm_idx + 1'b1;
      end else begin
        cm_idx <= '0;
      end
    end
  end

  // Status of the last accepted write
  always_ff @(posedge clk) begin
    if (rst) begin
      last_addr <= '0;
      last_data <= '0;
    end else if (acc) begin
      last_addr <= s_addr;
      last_data <= s_data;
    end
  end

  logic              pb_vld;
  logic [DATA_W-1:0] pb_data;

  pgload_pagebuf #(.IDX_W(BYTE_W), .DATA_W(DATA_W)) u_pagebuf (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (buf_we),
    .wr_idx   (s_addr[BYTE_W-1:0]),
    .wr_data  (s_data),
    .clr_mask (clr_mask),
    .rd_idx   (cm_idx),
    .rd_vld   (pb_vld),
    .rd_data  (pb_data)
  );

  // Commit pipeline: slot read, then registered array write beat
  always_ff @(posedge clk) begin
    if (rst) begin
      commit_q  <= 1'b0;
      idx_q     <= '0;
      arr_we    <= 1'b0;
      arr_waddr <= '0;
      arr_wdata <= '0;
    end else begin
      commit_q  <= (st == ST_COMMIT);
      idx_q     <= cm_idx;
      arr_we    <= commit_q && pb_vld;
      arr_waddr <= {page_q, idx_q};
      arr_wdata <= pb_data;
    end
  end

  pgload_array #(.AW(MEM_AW), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .we    (arr_we),
    .waddr (arr_waddr[MEM_AW-1:0]),
    .wdat  (arr_wdata),
    .raddr (rd_addr),
    .rdat  (rd_data)
  );

endmodule

// File: rtl/pgload_ctrl_chk.sv
module pgload_ctrl_chk #(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int BYTE_W   = 6,
  parameter int PROG_CYC = 2500000
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_waddr,
  input logic [ADDR_W-1:0] last_addr,
  input logic [DATA_W-1:0] last_data,
  input logic              loading
);

  localparam int PROG_MIN = (1 << BYTE_W) + 4;
  localparam int PROG_EFF = (PROG_CYC > PROG_MIN) ? PROG_CYC : PROG_MIN;

  int busy_len;

  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      busy_len <= 0;
    end else begin
      busy_len <= busy_len + 1;
    end
  end

  p_we_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);

  p_we_page_r3: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> (arr_waddr[ADDR_W-1:BYTE_W] == last_addr[ADDR_W-1:BYTE_W]));

  p_quiet_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(last_addr) && $stable(last_data)));

  p_page_fixed_r7: assert property (@(posedge clk) disable iff (rst)
    (loading && $past(loading)) |->
      (last_addr[ADDR_W-1:BYTE_W] == $past(last_addr[ADDR_W-1:BYTE_W])));

  p_busy_len_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_len == PROG_EFF));

endmodule

bind pgload_ctrl pgload_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .BYTE_W   (BYTE_W),
  .PROG_CYC (PROG_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .arr_we    (arr_we),
  .arr_waddr (arr_waddr),
  .last_addr (last_addr),
  .last_data (last_data),
  .loading   (st == pgload_pkg::ST_LOAD)
);

// File: tb/test_pgload_ctrl.sv
module test_pgload_ctrl;

  localparam int ADDR_W   = 13;
  localparam int DATA_W   = 8;
  localparam int BYTE_W   = 6;
  localparam int MEM_AW   = 11;
  localparam int LOAD_TO  = 20;
  localparam int PROG_CYC = 100;
  localparam int PROG_EXP = 100;
  localparam int DEPTH    = 1 << MEM_AW;
  localparam int NPAGES   = DEPTH >> BYTE_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              we_n = 1'b1;
  logic              ce_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic              wr_permit = 1'b1;
  logic [MEM_AW-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic              busy;
  logic [ADDR_W-1:0] last_addr;
  logic [DATA_W-1:0] last_data;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_waddr;
  logic [DATA_W-1:0] arr_wdata;

  int compared = 0;
  int mismatched = 0;
  int we_cnt = 0;
  bit finished = 1'b0;

  logic [DATA_W-1:0] mdl [DEPTH];
  logic [DATA_W-1:0] pend_d [64];
  bit                pend_v [64];
  logic [6:0]        pend_pg;

  always #2 clk = ~clk;

  pgload_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .MEM_AW(MEM_AW),
    .LOAD_TO(LOAD_TO), .PROG_CYC(PROG_CYC)
  ) i_pgload_ctrl (
    .clk(clk), .rst(rst), .we_n(we_n), .ce_n(ce_n), .addr(addr), .wdata(wdata),
    .wr_permit(wr_permit), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .last_addr(last_addr), .last_data(last_data), .arr_we(arr_we),
    .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
  );

  always @(negedge clk) begin
    if (arr_we) we_cnt <= we_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Write pulsed by both enables together
  task automatic wr(input logic [6:0] pg, input logic [5:0] idx, input logic [7:0] d);
    @(negedge clk);
    addr = {pg, idx}; we_n = 1'b0; ce_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; addr = ~{pg, idx}; wdata = d;
  endtask

  task automatic put(input logic [6:0] pg, input logic [5:0] idx, input logic [7:0] d);
    wr(pg, idx, d);
    pend_pg = pg; pend_d[idx] = d; pend_v[idx] = 1'b1;
  endtask

  task automatic apply_model();
    for (int i = 0; i < 64; i++) begin
      if (pend_v[i]) mdl[{pend_pg[4:0], i[5:0]}] = pend_d[i];
      pend_v[i] = 1'b0;
    end
  endtask

  task automatic wait_done();
    idle(LOAD_TO + 3);
    while (busy) @(negedge clk);
    idle(2);
    apply_model();
  endtask

  task automatic rd(input logic [MEM_AW-1:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic verify_all(input string req);
    logic [7:0] v;
    for (int i = 0; i < DEPTH; i++) begin
      rd(MEM_AW'(i), v);
      chk(req, {24'd0, v}, {24'd0, mdl[i]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int w0;
    int n;
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    for (int i = 0; i < 64; i++) begin pend_v[i] = 1'b0; pend_d[i] = '0; end
    pend_pg = '0;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 arr_we", {31'd0, arr_we}, 0);
    chk("R1 last_addr", {19'd0, last_addr}, 0);
    chk("R1 last_data", {24'd0, last_data}, 0);

    // R3: full page in descending order
    w0 = we_cnt;
    for (int i = 63; i >= 0; i--) put(7'd5, 6'(i), 8'(i * 7 + 3));
    wait_done();
    chk("R11 full page beats", we_cnt - w0, 64);

    // R4 rewrite, R10 status after last write
    w0 = we_cnt;
    put(7'd9, 6'd3, 8'hA1);
    put(7'd9, 6'd10, 8'h22);
    put(7'd9, 6'd3, 8'h5C);
    idle(2);
    chk("R10 last_addr", {19'd0, last_addr}, {19'd0, 7'd9, 6'd3});
    chk("R10 last_data", {24'd0, last_data}, 32'h5C);
    wait_done();
    chk("R4 rewrite beats", we_cnt - w0, 2);

    // R5/R11: sparse reload of an already written page
    w0 = we_cnt;
    put(7'd5, 6'd1, 8'hE1);
    put(7'd5, 6'd62, 8'hE2);
    wait_done();
    chk("R11 sparse beats", we_cnt - w0, 2);
    verify_all("R5 sparse page");

    // R6 timeout edge, R8 busy length
    put(7'd12, 6'd0, 8'h31);
    idle(LOAD_TO + 1);
    chk("R6 before timeout", {31'd0, busy}, 0);
    idle(1);
    chk("R6 at timeout", {31'd0, busy}, 1);
    n = 0;
    while (busy && n < 100000) begin n++; @(negedge clk); end
    chk("R8 busy length", n, PROG_EXP);
    idle(2);
    apply_model();

    // R6 gap of exactly LOAD_TO accepted, LOAD_TO+1 rejected (R8 ignore when busy)
    put(7'd13, 6'd0, 8'h40);
    idle(LOAD_TO - 2);
    put(7'd13, 6'd1, 8'h41);
    idle(LOAD_TO - 1);
    wr(7'd13, 6'd2, 8'h42);
    idle(2);
    chk("R8 ignored while busy", {19'd0, last_addr}, {19'd0, 7'd13, 6'd1});
    wait_done();

    // R7 foreign page write: ignored, window not extended
    put(7'd14, 6'd4, 8'h55);
    wr(7'd15, 6'd4, 8'h66);
    idle(LOAD_TO - 1);
    chk("R7 window not extended (before)", {31'd0, busy}, 0);
    idle(1);
    chk("R7 window not extended (at)", {31'd0, busy}, 1);
    chk("R7 status unchanged", {24'd0, last_data}, 32'h55);
    wait_done();

    // R9 write without permission
    w0 = we_cnt;
    wr_permit = 1'b0;
    wr(7'd20, 6'd7, 8'h77);
    idle(2);
    chk("R9 busy without permit", {31'd0, busy}, 1);
    chk("R10 unpermitted status", {19'd0, last_addr}, {19'd0, 7'd20, 6'd7});
    wr_permit = 1'b1;
    wr(7'd20, 6'd8, 8'h78);
    wait_done();
    chk("R9 no array beats", we_cnt - w0, 0);

    // R2: enable-controlled pulse variants
    @(negedge clk); we_n = 1'b0; ce_n = 1'b1; addr = {7'd22, 6'd9};
    @(negedge clk); ce_n = 1'b0; addr = {7'd22, 6'd17};
    @(negedge clk); we_n = 1'b1; addr = '0; wdata = 8'h9A;
    @(negedge clk); ce_n = 1'b1; wdata = 8'h00;
    pend_pg = 7'd22; pend_d[17] = 8'h9A; pend_v[17] = 1'b1;
    @(negedge clk); ce_n = 1'b0; addr = {7'd22, 6'd30};
    @(negedge clk); we_n = 1'b0; addr = {7'd22, 6'd33};
    @(negedge clk); ce_n = 1'b1; addr = '0; wdata = 8'hB4;
    @(negedge clk); we_n = 1'b1; wdata = 8'h00;
    pend_d[33] = 8'hB4; pend_v[33] = 1'b1;
    idle(2);
    chk("R2 later fall address", {19'd0, last_addr}, {19'd0, 7'd22, 6'd33});
    chk("R2 first rise data", {24'd0, last_data}, 32'hB4);
    wait_done();

    // R3/R4 sweep over every page
    for (int p = 0; p < NPAGES; p++) begin
      put(7'(p), 6'((p * 5) % 64), 8'(p * 3 + 1));
      put(7'(p), 6'((p * 11 + 7) % 64), 8'(p * 13 + 2));
      put(7'(p), 6'((p * 5) % 64), 8'(p * 3 + 129));
      wait_done();
    end
    verify_all("R3 sweep");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule